// File: doc/BRIEF.md
# Modulo 2^N-1 Residue Adder with Single-Zero Correction

This block adds two N-bit residues of the modulus 2^N-1 in one combinational pass. The two operands go through a Brent-Kung parallel prefix carry network. The network yields two things: the carry out of the top bit, and the group propagate across all N bit positions. Either of them raises an increment request. A binary-to-excess-one unit then adds one to the raw binary sum when that request is raised. This gives the end-around carry, and it also folds the all-ones encoding of zero back to all zeros. No separate zero detector is needed.

The adder is meant for one channel of a residue-number datapath, for example inside a residue-to-binary converter. Each operand must be a canonical residue in the range 0 to 2^N-2. The result is always canonical as well, so it can feed the next modular stage directly. The width N is a parameter, and widths that are not a power of two are supported.

Top module: `mod2n1_adder`

## Requirements
- R1: For operands in 0..2^N-2, `sum_o` equals (`opa_i` + `opb_i`) mod (2^N-1), and it settles combinationally with no clock.
- R2: For canonical operands, `sum_o` is never the all-ones word 2^N-1.
- R3: When the operand total is exactly 2^N-1 (for example an operand and its bitwise complement), `sum_o` is all zeros. The prefix carry out and the full-width group propagate are never both asserted.
- R4: When the operand total is 2^N or more, `sum_o` equals total - 2^N + 1, so the carry wraps around into bit 0.
- R5: When the total is below 2^N-1 and neither operand is zero, `sum_o` equals the plain binary total, because the increment path leaves the raw sum untouched.
- R6: A zero operand gives the other operand unchanged, and 0 + 0 gives 0.
- R7: Correct results hold for N = 4, 5, 8, 12 and 16, including widths that are not powers of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | N | First residue operand, 0..2^N-2 |
| opb_i | input | N | Second residue operand, 0..2^N-2 |
| sum_o | output | N | Canonical residue of the operand sum |

## Verification
Two properties are checked inside the RTL whenever the inputs change. The first is that the carry out and the all-bit propagate exclude each other. The second is that the excess-one unit passes the raw sum through unchanged when no increment is requested. With canonical inputs, the RTL also checks that the result is never all ones and that it matches the modular sum. Other behaviours can only be shown by the bench's scenarios: the wrap-around of the carry at the exact operand totals, the complement pairs that must collapse to zero, and the behaviour at widths that are not powers of two. The bench sweeps every operand pair at N = 4, 5 and 8, and it covers N = 12 and 16 with directed extremes plus random pairs.

// File: rtl/mod2n1_pkg.sv
`timescale 1ns/1ps
// Package: shared elaboration helpers for the modulo 2^N-1 adder.
// Assumes widths of at least 2 bits.
package mod2n1_pkg;

    // Number of Brent-Kung levels needed to span n bit positions.
    function automatic int bk_levels(input int n);
        int lv;
        lv = 0;
        while ((1 << lv) < n) lv++;
        return lv;
    endfunction

endpackage

// File: rtl/mod_pg_pre.sv
`timescale 1ns/1ps
// Module: mod_pg_pre
// Per-bit preprocessing of the prefix adder: generate is the AND of the
// operand bits, propagate is their XOR. Assumes no incoming carry.
module mod_pg_pre #(
    parameter int N = 8
) (
    input  logic [N-1:0] opa_i,
    input  logic [N-1:0] opb_i,
    output logic [N-1:0] gen_o,
    output logic [N-1:0] prp_o
);

    // Bitwise generate and propagate terms.
    always_comb begin
        gen_o = opa_i & opb_i;
        prp_o = opa_i ^ opb_i;
    end

endmodule

// File: rtl/mod_bk_tree.sv
`timescale 1ns/1ps
// Module: mod_bk_tree
// Brent-Kung prefix carry network. The bit vector is padded up to a power
// of two. An up-sweep builds power-of-two aligned groups, and a down-sweep
// fills in the remaining prefixes. Outputs the group generate G[i:0] for
// every bit (the carry out of bit i) and the group propagate P[N-1:0].
// Assumes N >= 2 and a zero carry into bit 0.
module mod_bk_tree
    import mod2n1_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prp_i,
    output logic [N-1:0] carry_o,
    output logic         allp_o
);

    localparam int L = bk_levels(N);
    localparam int W = 1 << L;
    localparam int D = L - 1;

    logic [W-1:0] ug [0:L];
    logic [W-1:0] up [0:L];
    logic [W-1:0] dg [0:D];
    logic [W-1:0] dp [0:D];

    // Load the padded level-0 terms; pad bits neither generate nor propagate.
    for (genvar i = 0; i < W; i++) begin : g_load
        if (i < N) begin : g_real
            assign ug[0][i] = gen_i[i];
            assign up[0][i] = prp_i[i];
        end else begin : g_pad
            assign ug[0][i] = 1'b0;
            assign up[0][i] = 1'b0;
        end
    end

    // Up-sweep: merge the aligned group of size 2^l below each node.
    for (genvar l = 0; l < L; l++) begin : g_up
        for (genvar i = 0; i < W; i++) begin : g_node
            if (((i + 1) % (2 << l)) == 0) begin : g_black
                assign ug[l+1][i] = ug[l][i] | (up[l][i] & ug[l][i-(1<<l)]);
                assign up[l+1][i] = up[l][i] & up[l][i-(1<<l)];
            end else begin : g_buf
                assign ug[l+1][i] = ug[l][i];
                assign up[l+1][i] = up[l][i];
            end
        end
    end

    assign dg[0] = ug[L];
    assign dp[0] = up[L];

    // Down-sweep: extend mid-span nodes with the full prefix below them.
    for (genvar k = 0; k < D; k++) begin : g_down
        localparam int S = 1 << (L - 2 - k);
        for (genvar i = 0; i < W; i++) begin : g_node
            if ((((i + 1) % (2 * S)) == S) && (i >= 3 * S - 1)) begin : g_black
                assign dg[k+1][i] = dg[k][i] | (dp[k][i] & dg[k][i-S]);
                assign dp[k+1][i] = dp[k][i] & dp[k][i-S];
            end else begin : g_buf
                assign dg[k+1][i] = dg[k][i];
                assign dp[k+1][i] = dp[k][i];
            end
        end
    end

    // Export the prefixes of the real bit positions.
    always_comb begin
        carry_o = dg[D][N-1:0];
        allp_o  = dp[D][N-1];
    end

    logic unused_tree;
    assign unused_tree = ^{dg[D], dp[D]};

    // A group cannot both generate and propagate a carry.
    always_comb begin
        p_cout_allp_excl_r3: assert (!(carry_o[N-1] && allp_o))
            else $error("carry out and full propagate both set");
    end

endmodule

// File: rtl/mod_excess_one.sv
`timescale 1ns/1ps
// Module: mod_excess_one
// Conditional binary-to-excess-one converter. When inc_i is set, bit i flips
// if all lower bits of the raw sum are ones (a prefix AND chain). This gives
// raw + 1 modulo 2^N. Assumes inc_i comes from the prefix network.
module mod_excess_one #(
    parameter int N = 8
) (
    input  logic [N-1:0] raw_i,
    input  logic         inc_i,
    output logic [N-1:0] sum_o
);

    logic [N:0] run;

    assign run[0] = inc_i;

    // Ripple the "all lower ones" condition and toggle each bit.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign run[i+1]  = run[i] & raw_i[i];
        assign sum_o[i]  = raw_i[i] ^ run[i];
    end

    logic unused_top;
    assign unused_top = run[N];

    // Without an increment request the raw sum passes through unchanged.
    always_comb begin
        p_passthru_r5: assert (inc_i || (sum_o == raw_i))
            else $error("excess-one unit altered sum with no request");
    end

endmodule

// File: rtl/mod2n1_adder.sv
`timescale 1ns/1ps
// Module: mod2n1_adder
// Combinational adder modulo 2^N-1 with a single zero encoding. A Brent-Kung
// prefix adder forms the raw sum. Its carry out or its full-width propagate
// requests an increment, which the excess-one unit applies.
// Assumes both operands are canonical residues (never all ones).
module mod2n1_adder #(
    parameter int N = 8
) (
    input  logic [N-1:0] opa_i,
    input  logic [N-1:0] opb_i,
    output logic [N-1:0] sum_o
);

    localparam logic [N-1:0] ONES = {N{1'b1}};

    logic [N-1:0] gen;
    logic [N-1:0] prp;
    logic [N-1:0] carry;
    logic         allp;
    logic [N-1:0] raw;
    logic         inc;

    mod_pg_pre #(.N(N)) u_pre (
        .opa_i (opa_i),
        .opb_i (opb_i),
        .gen_o (gen),
        .prp_o (prp)
    );

    mod_bk_tree #(.N(N)) u_tree (
        .gen_i   (gen),
        .prp_i   (prp),
        .carry_o (carry),
        .allp_o  (allp)
    );

    // Postprocessing: raw sum bits from propagate and incoming prefix carry.
    always_comb begin
        raw[0] = prp[0];
        for (int i = 1; i < N; i++) raw[i] = prp[i] ^ carry[i-1];
    end

    // Increment request: end-around carry, or raw sum equal to all ones.
    assign inc = carry[N-1] | allp;

    mod_excess_one #(.N(N)) u_inc (
        .raw_i (raw),
        .inc_i (inc),
        .sum_o (sum_o)
    );

    // Canonical inputs must give a canonical, correct residue.
    always_comb begin
        if ((opa_i != ONES) && (opb_i != ONES)) begin
            p_no_all_ones_r2: assert (sum_o != ONES)
                else $error("all-ones result from canonical inputs");
            p_mod_value_r1: assert ({1'b0, sum_o} ==
                                    (({1'b0, opa_i} + {1'b0, opb_i}) % {1'b0, ONES}))
                else $error("modular sum mismatch");
        end
    end

endmodule

// File: tb/tb_mod2n1_adder.sv
`timescale 1ns/1ps
// Bench: exhaustive sweeps at N = 4, 5 and 8; directed extremes plus
// random pairs at N = 12 and 16. Expected values are computed arithmetically.
module tb_mod2n1_adder;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [3:0]  a4,  b4;  logic [3:0]  s4;
    logic [4:0]  a5,  b5;  logic [4:0]  s5;
    logic [7:0]  a8,  b8;  logic [7:0]  s8;
    logic [11:0] a12, b12; logic [11:0] s12;
    logic [15:0] a16, b16; logic [15:0] s16;

    mod2n1_adder #(.N(4))  dut4  (.opa_i(a4),  .opb_i(b4),  .sum_o(s4));
    mod2n1_adder #(.N(5))  dut5  (.opa_i(a5),  .opb_i(b5),  .sum_o(s5));
    mod2n1_adder #(.N(8))  dut   (.opa_i(a8),  .opb_i(b8),  .sum_o(s8));
    mod2n1_adder #(.N(12)) dut12 (.opa_i(a12), .opb_i(b12), .sum_o(s12));
    mod2n1_adder #(.N(16)) dut16 (.opa_i(a16), .opb_i(b16), .sum_o(s16));

    // Compare one result against the arithmetic reference; tag by case.
    task automatic check(input int n, input longint a, input longint b, input longint got);
        longint m, expv;
        string tag;
        m    = (64'd1 << n) - 1;
        expv = (a + b) % m;
        if (a + b == m)             tag = "R3";
        else if (a + b >= m + 1)    tag = "R4";
        else if (a == 0 || b == 0)  tag = "R6";
        else                        tag = "R5";
        if (n >= 12) tag = {tag, " R7"};
        n_run++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL R1 %s N=%0d a=%0d b=%0d actual=%0d expected=%0d",
                     tag, n, a, b, got, expv);
        end
        n_run++;
        if (got == m) begin
            n_fail++;
            $display("FAIL R2 N=%0d a=%0d b=%0d actual=%0d expected=not %0d",
                     n, a, b, got, m);
        end
    endtask

    // Apply one pair at a given width, check mid-cycle.
    task automatic apply(input int n, input longint a, input longint b);
        @(posedge clk);
        case (n)
            4:  begin a4  = a[3:0];  b4  = b[3:0];  end
            5:  begin a5  = a[4:0];  b5  = b[4:0];  end
            8:  begin a8  = a[7:0];  b8  = b[7:0];  end
            12: begin a12 = a[11:0]; b12 = b[11:0]; end
            default: begin a16 = a[15:0]; b16 = b[15:0]; end
        endcase
        @(negedge clk);
        case (n)
            4:  check(n, a, b, longint'(s4));
            5:  check(n, a, b, longint'(s5));
            8:  check(n, a, b, longint'(s8));
            12: check(n, a, b, longint'(s12));
            default: check(n, a, b, longint'(s16));
        endcase
    endtask

    // Directed extremes for a width: zeros, complements, maxima (R3, R4, R6).
    task automatic directed(input int n);
        longint m;
        m = (64'd1 << n) - 1;
        apply(n, 0, 0);
        apply(n, 0, m - 1);
        apply(n, m - 1, 0);
        apply(n, m - 1, m - 1);
        apply(n, 1, m - 1);
        apply(n, 5, m - 5);
        apply(n, m - 1, 2);
        apply(n, m / 2, m / 2 + 1);
    endtask

    initial begin
        a4 = '0; b4 = '0; a5 = '0; b5 = '0; a8 = '0; b8 = '0;
        a12 = '0; b12 = '0; a16 = '0; b16 = '0;
        // Zero-input state before any sweep: every output must be 0 (R6).
        @(negedge clk);
        n_run++;
        if ({s4, s5, s8, s12, s16} != '0) begin
            n_fail++;
            $display("FAIL R6 initial zero inputs actual=%0h expected=0",
                     {s4, s5, s8, s12, s16});
        end
        // Exhaustive sweeps over canonical operands (R1..R6).
        for (int a = 0; a < 15; a++)  for (int b = 0; b < 15; b++)  apply(4, a, b);
        for (int a = 0; a < 31; a++)  for (int b = 0; b < 31; b++)  apply(5, a, b);
        for (int a = 0; a < 255; a++) for (int b = 0; b < 255; b++) apply(8, a, b);
        // Wider widths: directed extremes then random pairs (R7).
        directed(12);
        directed(16);
        for (int k = 0; k < 2000; k++) apply(12, $urandom % 4095, $urandom % 4095);
        for (int k = 0; k < 2000; k++) apply(16, $urandom % 65535, $urandom % 65535);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule